// File: doc/BRIEF.md
# Register-Triggered Interrupt Acknowledge Unit

This block sits on a host register port for a host that cannot run a native interrupt acknowledge cycle itself. The host picks one of seven acknowledge registers, one per VMEbus interrupt level, and reads it. The unit works out the level from the register offset and sends it to an external IACK engine with a start strobe. It then holds the host read open until the engine reports an outcome.

When the engine finishes, the read returns the 16-bit Status/ID of the interrupter that answered. The low byte of that word is the interrupter's logical address and the high byte is free for the interrupter to define. If this unit is the interrupter that answered, the engine raises a self flag. The unit then builds the word itself, with its eight local condition flags in the high byte and its own logical address in the low byte. A bus error or timeout from the engine ends the read with an error flag and all-ones data.

Requests that are not reads of an acknowledge register are left alone. They start no cycle and get no response from this unit.

Top module: `iack_reg_unit`

## Requirements
- R1: A read of byte offset 0x32, 0x34, 0x36, 0x38, 0x3A, 0x3C or 0x3E drives `eng_level` to 1, 2, 3, 4, 5, 6 or 7 in that order, i.e. (offset − 0x30)/2, while `eng_start` is high.
- R2: An accepted acknowledge read raises `eng_start` for exactly one cycle, in the cycle after the request is sampled.
- R3: A read of any other offset (odd offsets, 0x30 and everything outside 0x32..0x3E), and any write to any offset including the acknowledge offsets, raises neither `eng_start` nor `hst_rvalid`.
- R4: After an acknowledge read is accepted, `hst_rvalid` stays low until the engine reports `eng_done` or `eng_fail`, however long that takes.
- R5: When `eng_done` is sampled with `eng_self` low, the next cycle shows `hst_rvalid` high for one cycle, `hst_err` low, and `hst_rdata` equal to the `eng_sid` word sampled with `eng_done`.
- R6: When `eng_done` is sampled with `eng_self` high, `hst_rdata` is {`loc_flags`, `loc_laddr`}. Bits 15..8 are, from high to low: local interrupt 3, local interrupt 2, local interrupt 1, power-fail interrupt, back-off, trigger interrupt, system fail, power fail (`loc_flags[7]` down to `loc_flags[0]`). Bits 7..0 are the unit's logical address.
- R7: When `eng_fail` is sampled, the next cycle shows `hst_rvalid` and `hst_err` high and `hst_rdata` = 16'hFFFF. `eng_fail` takes precedence over `eng_done`.
- R8: While an acknowledge is in progress, further host requests are ignored: no new `eng_start`, and the pending result is unchanged.
- R9: During and right after reset, `eng_start`, `hst_rvalid` and `hst_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host request strobe, one cycle |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 8 | Byte offset of the request |
| hst_rvalid | output | 1 | Read result valid, one cycle |
| hst_err | output | 1 | Result is an error response |
| hst_rdata | output | 16 | Status/ID word or all ones on error |
| eng_start | output | 1 | Start strobe to the IACK engine |
| eng_level | output | 3 | Interrupt level to acknowledge, 1..7 |
| eng_done | input | 1 | Engine completed the acknowledge |
| eng_fail | input | 1 | Engine saw bus error or timeout |
| eng_self | input | 1 | The responding interrupter is this unit |
| eng_sid | input | 16 | Status/ID captured by the engine |
| loc_flags | input | 8 | Local interrupt condition flags |
| loc_laddr | input | 8 | This unit's logical address |

## Verification
Every one of the 256 offsets is read once. This separates the seven acknowledge offsets from their odd and boundary neighbours (0x30, 0x31, 0x33, 0x3F, 0x40) and checks the level code for each hit. Writes are swept over the same range to show that direction alone blocks a cycle. Each acknowledge level is then completed in three ways: by a remote interrupter, by the local interrupter with varied flag patterns, and by an engine failure with and without a simultaneous done. These runs tell the remote path, the locally formed word and the error override apart. Engine latencies vary from one to several cycles and extra requests are injected while busy, which exposes a premature response or a lost pending result.

// File: rtl/iack_pkg.sv
package iack_pkg;

  typedef logic [15:0] sid_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_t;

  // Level number for an offset inside the acknowledge window.
  function automatic logic [2:0] level_of(input logic [15:0] off, input logic [15:0] base);
    logic [15:0] diff;
    diff = off - base;
    return diff[3:1];
  endfunction

  // Locally formed Status/ID: condition flags high, own address low.
  function automatic sid_t local_sid(input logic [7:0] flags, input logic [7:0] laddr);
    return {flags, laddr};
  endfunction

endpackage

// File: rtl/iack_decode.sv
module iack_decode #(
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h30,
  parameter int NLVL   = 7,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [LVL_W-1:0]  level
);
  import iack_pkg::*;

  logic [NLVL-1:0]  hit_vec;
  logic [LVL_W-1:0] idx_level;

  // One comparator per acknowledge register.
  for (genvar k = 0; k < NLVL; k++) begin : g_cmp
    localparam int OFF = BASE + 2 * (k + 1);
    assign hit_vec[k] = (addr == ADDR_W'(OFF));
  end

  assign hit = |hit_vec;

  // Level taken arithmetically from the offset.
  assign level = LVL_W'(level_of(16'(addr), 16'(BASE)));

  // Level taken from the comparator index, used only for checking.
  always_comb begin
    idx_level = '0;
    for (int k = 0; k < NLVL; k++)
      if (hit_vec[k]) idx_level = idx_level | LVL_W'(k + 1);
  end

  p_onehot_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_level_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (level == idx_level));

endmodule

// File: rtl/iack_sid_former.sv
module iack_sid_former (
  input  logic              fail,
  input  logic              self_hit,
  input  iack_pkg::sid_t    eng_sid,
  input  logic [7:0]        flags,
  input  logic [7:0]        laddr,
  output iack_pkg::sid_t    result,
  output logic              is_err
);
  import iack_pkg::*;

  always_comb begin
    is_err = fail;
    if (fail)          result = '1;
    else if (self_hit) result = local_sid(flags, laddr);
    else               result = eng_sid;
  end

endmodule

// File: rtl/iack_seq.sv
module iack_seq #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_rd,
  input  logic [LVL_W-1:0] acc_level,
  input  logic             eng_done,
  input  logic             eng_fail,
  input  iack_pkg::sid_t   res_word,
  input  logic             res_err,
  output logic             idle,
  output logic             eng_start,
  output logic [LVL_W-1:0] eng_level,
  output logic             rvalid,
  output logic             rerr,
  output iack_pkg::sid_t   rdata
);
  import iack_pkg::*;

  seq_state_t st, st_nx;
  logic       fire;     // request accepted this cycle
  logic       finish;   // engine outcome accepted this cycle

  assign idle   = (st == ST_IDLE);
  assign fire   = idle && acc_rd;
  assign finish = (st == ST_WAIT) && (eng_done || eng_fail);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (fire) st_nx = ST_START;
      ST_START: st_nx = ST_WAIT;
      ST_WAIT:  if (finish) st_nx = ST_RESP;
      ST_RESP:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      eng_level <= '0;
      rdata     <= '0;
      rerr      <= 1'b0;
    end else begin
      st <= st_nx;
      if (fire) eng_level <= acc_level;
      if (finish) begin
        rdata <= res_word;
        rerr  <= res_err;
      end else if (st == ST_RESP) begin
        rerr  <= 1'b0;
      end
    end
  end

  assign eng_start = (st == ST_START);
  assign rvalid    = (st == ST_RESP);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_start) |-> $past(acc_rd));

  p_level_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_level != '0));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(eng_done || eng_fail));

  p_err_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rerr) |-> (rdata == '1));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && acc_rd) |=> !eng_start);

  p_quiet_reset_r9: assert property (@(posedge clk)
    !rst_n |-> (!eng_start && !rvalid));

endmodule

// File: rtl/iack_reg_unit.sv
module iack_reg_unit #(
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h30,
  parameter int NLVL   = 7,
  localparam int LVL_W = $clog2(NLVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_req,
  input  logic              hst_we,
  input  logic [ADDR_W-1:0] hst_addr,
  output logic              hst_rvalid,
  output logic              hst_err,
  output logic [15:0]       hst_rdata,
  output logic              eng_start,
  output logic [LVL_W-1:0]  eng_level,
  input  logic              eng_done,
  input  logic              eng_fail,
  input  logic              eng_self,
  input  logic [15:0]       eng_sid,
  input  logic [7:0]        loc_flags,
  input  logic [7:0]        loc_laddr
);
  import iack_pkg::*;

  logic             dec_hit;
  logic [LVL_W-1:0] dec_level;
  logic             acc_rd;
  logic             seq_idle;
  sid_t             res_word;
  logic             res_err;

  iack_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NLVL(NLVL), .LVL_W(LVL_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (hst_addr),
    .hit   (dec_hit),
    .level (dec_level)
  );

  // Only reads of acknowledge registers are claimed.
  assign acc_rd = hst_req && !hst_we && dec_hit;

  iack_sid_former u_sid (
    .fail     (eng_fail),
    .self_hit (eng_self),
    .eng_sid  (eng_sid),
    .flags    (loc_flags),
    .laddr    (loc_laddr),
    .result   (res_word),
    .is_err   (res_err)
  );

  iack_seq #(.LVL_W(LVL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_rd    (acc_rd),
    .acc_level (dec_level),
    .eng_done  (eng_done),
    .eng_fail  (eng_fail),
    .res_word  (res_word),
    .res_err   (res_err),
    .idle      (seq_idle),
    .eng_start (eng_start),
    .eng_level (eng_level),
    .rvalid    (hst_rvalid),
    .rerr      (hst_err),
    .rdata     (hst_rdata)
  );

  p_write_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && hst_req && hst_we) |=> !eng_start);

  p_self_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rvalid && !hst_err && $past(eng_self && !eng_fail)) |->
      (hst_rdata == {$past(loc_flags), $past(loc_laddr)}));

  p_remote_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rvalid && $past(!eng_self && !eng_fail)) |->
      (!hst_err && hst_rdata == $past(eng_sid)));

endmodule

// File: tb/test_iack_reg_unit.sv
`timescale 1ns/1ps
module test_iack_reg_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 1'b0, hst_we = 1'b0;
  logic [7:0]  hst_addr = '0;
  logic        hst_rvalid, hst_err;
  logic [15:0] hst_rdata;
  logic        eng_start;
  logic [2:0]  eng_level;
  logic        eng_done = 1'b0, eng_fail = 1'b0, eng_self = 1'b0;
  logic [15:0] eng_sid = '0;
  logic [7:0]  loc_flags = '0, loc_laddr = 8'h5C;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  iack_reg_unit i_iack_reg_unit (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_rvalid(hst_rvalid), .hst_err(hst_err), .hst_rdata(hst_rdata),
    .eng_start(eng_start), .eng_level(eng_level), .eng_done(eng_done),
    .eng_fail(eng_fail), .eng_self(eng_self), .eng_sid(eng_sid),
    .loc_flags(loc_flags), .loc_laddr(loc_laddr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode: 0 remote done, 1 self done, 2 fail, 3 fail together with done
  task automatic access(input logic [7:0] a, input logic we, input int mode,
                        input int dly, input logic [15:0] esid, input logic [7:0] fl,
                        input bit poke_busy);
    bit       hit;
    int       lvl;
    logic [15:0] exp_d;
    hit = !we && (a % 2 == 0) && (a / 2 >= 25) && (a / 2 <= 31);
    lvl = a / 2 - 24;
    @(negedge clk);
    hst_req = 1'b1; hst_we = we; hst_addr = a;
    @(negedge clk);
    hst_req = 1'b0; hst_we = 1'b0;
    if (!hit) begin
      for (int i = 0; i < 3; i++) begin
        chk(!eng_start && !hst_rvalid, "R3 quiet", {eng_start, hst_rvalid}, 0);
        @(negedge clk);
      end
    end else begin
      chk(eng_start === 1'b1, "R2 start", eng_start, 1);
      chk(eng_level == 3'(lvl), "R1 level", eng_level, lvl);
      for (int i = 0; i < dly; i++) begin
        if (poke_busy && i == 0) begin hst_req = 1'b1; hst_addr = 8'h3E; end
        @(negedge clk);
        hst_req = 1'b0;
        chk(!hst_rvalid, "R4 stall", hst_rvalid, 0);
        chk(!eng_start, "R2 one pulse / R8 busy", eng_start, 0);
      end
      loc_flags = fl;
      eng_sid   = esid;
      eng_self  = (mode == 1);
      eng_done  = (mode != 2);
      eng_fail  = (mode >= 2);
      @(negedge clk);
      eng_done = 1'b0; eng_fail = 1'b0; eng_self = 1'b0;
      eng_sid  = ~esid; loc_flags = ~fl;
      if (mode >= 2) exp_d = 16'hFFFF;
      else if (mode == 1) exp_d = {fl, loc_laddr};
      else exp_d = esid;
      chk(hst_rvalid === 1'b1, "R4/R5 rvalid", hst_rvalid, 1);
      chk(hst_err === (mode >= 2), mode >= 2 ? "R7 err" : "R5 err", hst_err, mode >= 2);
      chk(hst_rdata == exp_d, mode == 0 ? "R5 data" : (mode == 1 ? "R6 data" : "R7 data"),
          hst_rdata, exp_d);
      @(negedge clk);
      chk(!hst_rvalid, "R5 one cycle", hst_rvalid, 0);
      chk(!eng_start, "R8 no restart", eng_start, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!eng_start && !hst_rvalid && !hst_err, "R9 reset", {eng_start, hst_rvalid, hst_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!eng_start && !hst_rvalid && !hst_err, "R9 after reset", {eng_start, hst_rvalid, hst_err}, 0);

    // Read sweep over all offsets, remote completion, latency follows offset.
    for (int a = 0; a < 256; a++)
      access(8'(a), 1'b0, 0, 1 + (a % 5), 16'hA500 ^ 16'(a * 37), 8'h00, 1'b0);
    // Write sweep: never claimed (R3).
    for (int a = 0; a < 256; a++)
      access(8'(a), 1'b1, 0, 1, 16'h0, 8'h00, 1'b0);
    // Per level: self word, failure, failure with done, busy injection.
    for (int l = 1; l <= 7; l++) begin
      access(8'(8'h30 + 2 * l), 1'b0, 1, l, 16'h1234, 8'(8'h01 << (l - 1)) ^ 8'hC3, 1'b0);
      access(8'(8'h30 + 2 * l), 1'b0, 2, 2, 16'h0F0F, 8'h00, 1'b0);
      access(8'(8'h30 + 2 * l), 1'b0, 3, 1, 16'h3C3C, 8'h00, 1'b0);
      access(8'(8'h30 + 2 * l), 1'b0, 0, 3, 16'(16'h0100 * l + l), 8'h00, 1'b1);
    end
    access(8'h34, 1'b0, 1, 4, 16'h0000, 8'hFF, 1'b0);
    access(8'h3A, 1'b0, 1, 1, 16'hFFFF, 8'h80, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule